// File: doc/BRIEF.md
# Multicart Outer Register Write Steering

This block sits between the CPU write bus of a multicart and the bank-switching core inside it. It holds eight outer registers and a small two-bit pattern latch. It decides, for every CPU write, whether the write lands in an outer register, in the latch, or is handed on to the core's bank-select port or its interrupt-counter port. Writes in the page 0x5000–0x5FFF reach outer registers 0–3. An address-match rule chosen by a switch setting that steps on every reset can gate them. Writes in 0x8000–0xFFFF go to the latch while the flat pattern mode is on. In extended mode, some of them are captured into registers 4–7. All other writes in that range pass through to the core.

The CPU write is a plain strobe with address and data. It is accepted on every clock edge where the strobe is high, and there is no back-pressure, because a CPU bus cycle cannot be stalled. The core strobes are combinational copies of the current write. They are valid only in the cycle the strobe is high, and the core must take them on that edge. A parameter selects the board variant that swaps two command codes on their way to the core.

Top module: `mc_outer_regs`

## Requirements
- R1: With the switch setting at 0, a write whose address bits 15:12 equal 0x5 stores the data byte in outer register number address[1:0] on the next clock edge.
- R2: With a switch setting S from 1 to 9, a low-page write is stored only if address bit S+3 is 1. If that bit is 0, no outer register takes the data.
- R3: After every low-page write, whether stored or not, bits 2:0 of register 0 are zero whenever bit 1 of register 3, as it stands after the write, is 1.
- R4: A reset pulse sets registers 0–3 to 0x00 and registers 4–7 to 0xFF. It leaves the pattern latch unchanged. It steps the switch setting 0,1,…,9 and then wraps it back to 0.
- R5: Power-on sets register 0 to 0x04, register 1 to 0xFF, registers 2 and 3 to 0x00, registers 4–7 to 0xFF, the latch to 0 and the switch setting to 0. Power-on takes priority over reset, and reset takes priority over a write in the same cycle.
- R6: While register 0 bit 6 is 1, a write with address bit 15 set goes to the latch and raises no core strobe. The latch becomes 0 if register 0 bits 5:4 are nonzero; otherwise it takes data[1:0].
- R7: While register 0 bit 6 is 0, register 3 bit 1 is 1 and command bit 3 is 1, a write to an odd address in 0x8000–0x9FFF stores the data in register 4 + command[1:0] and raises no core strobe.
- R8: Any other write with address bit 15 set raises the bank strobe if address bit 14 is 0, or the interrupt strobe if it is 1, in the same cycle, with the data on the core data output.
- R9: With the swap variant enabled, a bank-port write to an even address in 0x8000–0x9FFF sends 0x47 to the core for data 0x46, and 0x46 for data 0x47. Other values, and the plain variant, pass the data unchanged.
- R10: At most one core strobe is high at a time, and neither is high while power-on or reset is asserted.
- R11: A write outside 0x5000–0x5FFF with address bit 15 clear changes no register and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the CPU write strobe is sampled on its rising edge |
| por_i | input | 1 | Power-on, synchronous, highest priority |
| rst_i | input | 1 | Reset pulse, synchronous; steps the switch setting |
| cpu_we_i | input | 1 | CPU write strobe |
| cpu_addr_i | input | 16 | CPU address |
| cpu_data_i | input | 8 | CPU write data |
| core_cmd_ext_i | input | 1 | Command register bit 3 of the banking core |
| core_cmd_sel_i | input | 2 | Command register bits 1:0 of the banking core |
| oreg_o | output | 8x8 | Outer registers 0–7, register n in oreg_o[n] |
| chr_latch_o | output | 2 | Pattern latch used in flat mode |
| core_bank_we_o | output | 1 | Write strobe to the core's bank-select port |
| core_irq_we_o | output | 1 | Write strobe to the core's interrupt-counter port |
| core_data_o | output | 8 | Data for the core, after the variant swap |

## Verification
Core strobes and core data are combinational, so they are due in the cycle the write strobe is high. The bench drives each write just after a falling edge and samples the strobes one time step later, well before the next rising edge. Register, latch and switch effects take one edge: a write, reset or power-on applied in one low phase appears at the following falling edge, and the bench reads registers there. The switch setting is not a port. The bench reaches it through which low-page addresses are accepted after a counted number of reset pulses.

// File: rtl/mc_outer_pkg.sv
package mc_outer_pkg;
  localparam int DATA_W   = 8;
  localparam int N_LOW    = 4;
  localparam int N_EXT    = 4;
  localparam int N_REG    = N_LOW + N_EXT;
  localparam int SEL_W    = $clog2(N_LOW);
  localparam int LATCH_W  = 2;
  localparam int MODE_W   = 3;
  localparam int FLAT_BIT = 6;
  localparam int EXT_BIT  = 1;

  typedef enum logic [2:0] {
    WK_NONE,
    WK_LOW,
    WK_FLAT,
    WK_EXT,
    WK_BANK,
    WK_IRQ
  } wr_kind_e;

  function automatic logic [DATA_W-1:0] power_value(int idx);
    case (idx)
      0:       return 8'h04;
      1:       return 8'hFF;
      2, 3:    return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] reset_value(int idx);
    return (idx < N_LOW) ? 8'h00 : 8'hFF;
  endfunction

  function automatic logic [DATA_W-1:0] swap_code(logic [DATA_W-1:0] d);
    if (d == 8'h46) return 8'h47;
    if (d == 8'h47) return 8'h46;
    return d;
  endfunction
endpackage

// File: rtl/mc_wr_classify.sv
module mc_wr_classify
  import mc_outer_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [3:0]  LOW_PAGE = 4'h5
) (
  input  logic              we,
  input  logic              blocked,
  input  logic [ADDR_W-1:0] addr,
  input  logic              flat_mode,
  input  logic              ext_mode,
  input  logic              cmd_ext,
  output wr_kind_e          kind
);
  localparam int MSB = ADDR_W - 1;

  logic hi_range;
  logic data_port;

  assign hi_range  = addr[MSB];
  // bank data port: A15=1, A14=0, A13=0, A0=1
  assign data_port = (addr[MSB-1:MSB-2] == 2'b00) && addr[0];

  always_comb begin
    kind = WK_NONE;
    if (we && !blocked) begin
      if (addr[MSB -: 4] == LOW_PAGE) begin
        kind = WK_LOW;
      end else if (hi_range) begin
        if (flat_mode)                               kind = WK_FLAT;
        else if (ext_mode && cmd_ext && data_port)   kind = WK_EXT;
        else if (!addr[MSB-1])                       kind = WK_BANK;
        else                                         kind = WK_IRQ;
      end
    end
  end
endmodule

// File: rtl/mc_dip_ctr.sv
module mc_dip_ctr #(
  parameter int ADDR_W  = 16,
  parameter int DIP_MAX = 9,
  parameter int BIT_OFS = 3
) (
  input  logic              clk,
  input  logic              por,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  output logic              accept
);
  localparam int DIP_W = $clog2(DIP_MAX + 1);

  logic [DIP_W-1:0] dip_q;
  logic             bit_hit;

  always_ff @(posedge clk) begin
    if (por)
      dip_q <= '0;
    else if (rst)
      dip_q <= (dip_q == DIP_W'(DIP_MAX)) ? '0 : dip_q + 1'b1;
  end

  always_comb begin
    bit_hit = 1'b0;
    for (int b = 0; b < ADDR_W; b++) begin
      if (b == int'(dip_q) + BIT_OFS) bit_hit = addr[b];
    end
    accept = (dip_q == '0) || bit_hit;
  end
endmodule

// File: rtl/mc_outer_file.sv
module mc_outer_file
  import mc_outer_pkg::*;
(
  input  logic                          clk,
  input  logic                          por,
  input  logic                          rst,
  input  wr_kind_e                      kind,
  input  logic                          accept,
  input  logic [SEL_W-1:0]              sel,
  input  logic [SEL_W-1:0]              cmd_sel,
  input  logic [DATA_W-1:0]             data,
  output logic [N_REG-1:0][DATA_W-1:0]  regs,
  output logic [LATCH_W-1:0]            latch
);
  logic [N_REG-1:0][DATA_W-1:0] regs_q;
  logic [N_REG-1:0][DATA_W-1:0] regs_d;
  logic [LATCH_W-1:0]           latch_q;
  logic                         low_store;
  logic                         ext_after;
  logic                         latch_clear;

  assign low_store   = (kind == WK_LOW) && accept;
  assign ext_after   = (low_store && sel == SEL_W'(N_LOW - 1)) ? data[EXT_BIT]
                                                              : regs_q[N_LOW-1][EXT_BIT];
  assign latch_clear = |regs_q[0][5:4];

  for (genvar i = 0; i < N_REG; i++) begin : g_reg
    if (i < N_LOW) begin : g_low
      always_comb begin
        regs_d[i] = regs_q[i];
        if (kind == WK_LOW) begin
          if (low_store && sel == SEL_W'(i)) regs_d[i] = data;
          if (i == 0 && ext_after) regs_d[i][MODE_W-1:0] = '0;
        end
      end
    end else begin : g_ext
      always_comb begin
        regs_d[i] = regs_q[i];
        if (kind == WK_EXT && cmd_sel == SEL_W'(i - N_LOW)) regs_d[i] = data;
      end
    end

    always_ff @(posedge clk) begin
      if (por)      regs_q[i] <= power_value(i);
      else if (rst) regs_q[i] <= reset_value(i);
      else          regs_q[i] <= regs_d[i];
    end
  end

  always_ff @(posedge clk) begin
    if (por)
      latch_q <= '0;
    else if (!rst && kind == WK_FLAT)
      latch_q <= latch_clear ? '0 : data[LATCH_W-1:0];
  end

  assign regs  = regs_q;
  assign latch = latch_q;
endmodule

// File: rtl/mc_outer_regs.sv
module mc_outer_regs
  import mc_outer_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DIP_MAX  = 9,
  parameter bit CHR_SWAP = 1'b0
) (
  input  logic                          clk,
  input  logic                          por_i,
  input  logic                          rst_i,
  input  logic                          cpu_we_i,
  input  logic [ADDR_W-1:0]             cpu_addr_i,
  input  logic [DATA_W-1:0]             cpu_data_i,
  input  logic                          core_cmd_ext_i,
  input  logic [SEL_W-1:0]              core_cmd_sel_i,
  output logic [N_REG-1:0][DATA_W-1:0]  oreg_o,
  output logic [LATCH_W-1:0]            chr_latch_o,
  output logic                          core_bank_we_o,
  output logic                          core_irq_we_o,
  output logic [DATA_W-1:0]             core_data_o
);
  localparam int MSB = ADDR_W - 1;

  wr_kind_e                     kind;
  logic                         accept;
  logic [N_REG-1:0][DATA_W-1:0] regs;
  logic                         cmd_slot;

  mc_wr_classify #(.ADDR_W(ADDR_W)) u_classify (
    .we        (cpu_we_i),
    .blocked   (por_i | rst_i),
    .addr      (cpu_addr_i),
    .flat_mode (regs[0][FLAT_BIT]),
    .ext_mode  (regs[N_LOW-1][EXT_BIT]),
    .cmd_ext   (core_cmd_ext_i),
    .kind      (kind)
  );

  mc_dip_ctr #(.ADDR_W(ADDR_W), .DIP_MAX(DIP_MAX), .BIT_OFS(3)) u_dip (
    .clk    (clk),
    .por    (por_i),
    .rst    (rst_i),
    .addr   (cpu_addr_i),
    .accept (accept)
  );

  mc_outer_file u_file (
    .clk     (clk),
    .por     (por_i),
    .rst     (rst_i),
    .kind    (kind),
    .accept  (accept),
    .sel     (cpu_addr_i[SEL_W-1:0]),
    .cmd_sel (core_cmd_sel_i),
    .data    (cpu_data_i),
    .regs    (regs),
    .latch   (chr_latch_o)
  );

  // command port: A14=0, A13=0, A0=0
  assign cmd_slot = (cpu_addr_i[MSB-1:MSB-2] == 2'b00) && !cpu_addr_i[0];

  generate
    if (CHR_SWAP) begin : g_swap
      assign core_data_o = cmd_slot ? swap_code(cpu_data_i) : cpu_data_i;
    end else begin : g_plain
      assign core_data_o = cpu_data_i;
    end
  endgenerate

  assign core_bank_we_o = (kind == WK_BANK);
  assign core_irq_we_o  = (kind == WK_IRQ);
  assign oreg_o         = regs;
endmodule

// File: rtl/mc_outer_regs_chk.sv
module mc_outer_regs_chk
  import mc_outer_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic                          clk,
  input logic                          por_i,
  input logic                          rst_i,
  input logic                          cpu_we_i,
  input logic [ADDR_W-1:0]             cpu_addr_i,
  input logic [N_REG-1:0][DATA_W-1:0]  oreg_o,
  input logic [LATCH_W-1:0]            chr_latch_o,
  input logic                          core_bank_we_o,
  input logic                          core_irq_we_o
);
  localparam int MSB = ADDR_W - 1;

  // R5: power-on values one edge later
  a_r5_power_vals: assert property (@(posedge clk)
    por_i |=> (oreg_o[0] == 8'h04 && oreg_o[1] == 8'hFF && oreg_o[2] == 8'h00 &&
               oreg_o[3] == 8'h00 && oreg_o[7:4] == {4{8'hFF}} && chr_latch_o == '0));

  // R4: reset values one edge later
  a_r4_reset_vals: assert property (@(posedge clk) disable iff (por_i)
    rst_i |=> (oreg_o[3:0] == '0 && oreg_o[7:4] == {4{8'hFF}}));

  // R4: reset leaves the latch alone
  a_r4_latch_kept: assert property (@(posedge clk) disable iff (por_i)
    (rst_i || !(cpu_we_i && cpu_addr_i[MSB])) |=> $stable(chr_latch_o));

  // R3: mode bits cleared while extended mode is on after a low-page write
  a_r3_mode_forced: assert property (@(posedge clk) disable iff (por_i || rst_i)
    (cpu_we_i && cpu_addr_i[MSB -: 4] == 4'h5) |=>
      (!oreg_o[3][EXT_BIT] || oreg_o[0][MODE_W-1:0] == '0));

  // R6: flat mode keeps high writes away from the core
  a_r6_flat_no_core: assert property (@(posedge clk) disable iff (por_i || rst_i)
    (cpu_we_i && cpu_addr_i[MSB] && oreg_o[0][FLAT_BIT]) |-> !(core_bank_we_o || core_irq_we_o));

  // R10: strobes exclusive and silent under power-on or reset
  a_r10_one_strobe: assert property (@(posedge clk)
    $onehot0({core_bank_we_o, core_irq_we_o}));
  a_r10_quiet_in_reset: assert property (@(posedge clk)
    (por_i || rst_i) |-> !(core_bank_we_o || core_irq_we_o));

  // R11: writes outside both windows change nothing
  a_r11_ignored: assert property (@(posedge clk) disable iff (por_i || rst_i)
    (cpu_we_i && !cpu_addr_i[MSB] && cpu_addr_i[MSB -: 4] != 4'h5) |=> $stable(oreg_o));
endmodule

bind mc_outer_regs mc_outer_regs_chk u_chk (
  .clk            (clk),
  .por_i          (por_i),
  .rst_i          (rst_i),
  .cpu_we_i       (cpu_we_i),
  .cpu_addr_i     (cpu_addr_i),
  .oreg_o         (oreg_o),
  .chr_latch_o    (chr_latch_o),
  .core_bank_we_o (core_bank_we_o),
  .core_irq_we_o  (core_irq_we_o)
);

// File: tb/mc_outer_regs_test.sv
module mc_outer_regs_test;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              por = 1'b1;
  logic              rst = 1'b0;
  logic              we  = 1'b0;
  logic [15:0]       addr = '0;
  logic [7:0]        data = '0;
  logic              cmd_ext = 1'b0;
  logic [1:0]        cmd_sel = '0;
  logic [7:0][7:0]   oreg, oreg_p;
  logic [1:0]        latch, latch_p;
  logic              bank_we, irq_we, bank_we_p, irq_we_p;
  logic [7:0]        cdata, cdata_p;

  int n_checks = 0;
  int n_fail   = 0;
  logic s_bank, s_irq;
  logic [7:0] s_data, s_data_p;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_outer_regs #(.CHR_SWAP(1'b1)) uut (
    .clk(clk), .por_i(por), .rst_i(rst), .cpu_we_i(we), .cpu_addr_i(addr),
    .cpu_data_i(data), .core_cmd_ext_i(cmd_ext), .core_cmd_sel_i(cmd_sel),
    .oreg_o(oreg), .chr_latch_o(latch), .core_bank_we_o(bank_we),
    .core_irq_we_o(irq_we), .core_data_o(cdata));

  mc_outer_regs #(.CHR_SWAP(1'b0)) uut_plain (
    .clk(clk), .por_i(por), .rst_i(rst), .cpu_we_i(we), .cpu_addr_i(addr),
    .cpu_data_i(data), .core_cmd_ext_i(cmd_ext), .core_cmd_sel_i(cmd_sel),
    .oreg_o(oreg_p), .chr_latch_o(latch_p), .core_bank_we_o(bank_we_p),
    .core_irq_we_o(irq_we_p), .core_data_o(cdata_p));

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cpu_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; data = d; we = 1'b1;
    #1;
    s_bank = bank_we; s_irq = irq_we; s_data = cdata; s_data_p = cdata_p;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic reset_pulse();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic set_cmd(logic [3:0] c);
    cmd_ext = c[3]; cmd_sel = c[1:0];
  endtask

  task automatic t_power();
    @(negedge clk);
    por = 1'b1; rst = 1'b1; we = 1'b1; addr = 16'h5000; data = 8'h99;
    #1;
    check("R10 strobes in power/reset", {bank_we, irq_we}, 2'b00);
    @(negedge clk);
    por = 1'b0; rst = 1'b0; we = 1'b0;
    check("R5 power regs", oreg, {8'hFF,8'hFF,8'hFF,8'hFF,8'h00,8'h00,8'hFF,8'h04});
    check("R5 power latch", latch, 2'd0);
  endtask

  task automatic t_low_basic();
    cpu_write(16'h5000, 8'h11);
    cpu_write(16'h5001, 8'h33);
    cpu_write(16'h5002, 8'h22);
    cpu_write(16'h5003, 8'h01);
    check("R1 low-page stores", oreg[3:0], {8'h01,8'h22,8'h33,8'h11});
    check("R1 no core strobe", {s_bank, s_irq}, 2'b00);
  endtask

  task automatic t_force();
    cpu_write(16'h5003, 8'h02);
    check("R3 mode bits cleared by reg3 write", oreg[0], 8'h10);
    cpu_write(16'h5000, 8'h07);
    check("R3 mode bits cleared on reg0 write", oreg[0], 8'h00);
    cpu_write(16'h5002, 8'h5D);
    check("R3 other low write", {oreg[2], oreg[0]}, {8'h5D, 8'h00});
  endtask

  task automatic t_ignore();
    cpu_write(16'h6000, 8'hAA);
    check("R11 strobes", {s_bank, s_irq}, 2'b00);
    cpu_write(16'h4003, 8'hBB);
    cpu_write(16'h7FFF, 8'hCC);
    check("R11 regs unchanged", oreg,
          {8'hFF,8'hFF,8'hFF,8'hFF,8'h02,8'h5D,8'h33,8'h00});
  endtask

  task automatic t_ext();
    set_cmd(4'hA);
    cpu_write(16'h8001, 8'h5A);
    check("R7 reg6 captured", oreg[6], 8'h5A);
    check("R7 no strobe", {s_bank, s_irq}, 2'b00);
    set_cmd(4'hF);
    cpu_write(16'h9FFF, 8'h3C);
    check("R7 reg7 via odd mirror", oreg[7], 8'h3C);
    set_cmd(4'h8);
    cpu_write(16'h8003, 8'hC4);
    check("R7 reg4 captured", oreg[4], 8'hC4);
    set_cmd(4'h2);
    cpu_write(16'h8001, 8'h71);
    check("R8 cmd bit3 clear passes to bank", {s_bank, s_irq, s_data}, {2'b10, 8'h71});
    check("R7 reg5 untouched", oreg[5], 8'hFF);
  endtask

  task automatic t_pass();
    set_cmd(4'hA);
    cpu_write(16'hA001, 8'h12);
    check("R8 A001 to bank", {s_bank, s_irq, s_data}, {2'b10, 8'h12});
    check("R8 reg6 kept", oreg[6], 8'h5A);
    cpu_write(16'hC000, 8'h56);
    check("R8 C000 to irq", {s_bank, s_irq, s_data}, {2'b01, 8'h56});
    cpu_write(16'hE001, 8'h78);
    check("R8 E001 to irq", {s_bank, s_irq}, 2'b01);
  endtask

  task automatic t_swap();
    set_cmd(4'h0);
    cpu_write(16'h8000, 8'h46);
    check("R9 46 swapped / plain", {s_data, s_data_p}, {8'h47, 8'h46});
    cpu_write(16'h8000, 8'h47);
    check("R9 47 swapped / plain", {s_data, s_data_p}, {8'h46, 8'h47});
    cpu_write(16'h8001, 8'h46);
    check("R9 odd address not swapped", s_data, 8'h46);
    cpu_write(16'h8000, 8'h48);
    check("R9 other value", s_data, 8'h48);
    cpu_write(16'h9FFE, 8'h46);
    check("R9 even mirror swapped", s_data, 8'h47);
  endtask

  task automatic t_flat();
    cpu_write(16'h5000, 8'h40);
    cpu_write(16'hC000, 8'h03);
    check("R6 latch loaded", latch, 2'd3);
    check("R6 no strobe", {s_bank, s_irq}, 2'b00);
    set_cmd(4'hA);
    cpu_write(16'h8001, 8'h01);
    check("R6 flat beats extended", {latch, oreg[6]}, {2'd1, 8'h5A});
    cpu_write(16'h5000, 8'h50);
    cpu_write(16'h8000, 8'h02);
    check("R6 latch cleared by bits 5:4", latch, 2'd0);
    cpu_write(16'h5000, 8'h40);
    cpu_write(16'h8000, 8'h02);
    check("R6 latch reload", latch, 2'd2);
  endtask

  task automatic t_reset_dip();
    reset_pulse();
    check("R4 reset regs", oreg, {8'hFF,8'hFF,8'hFF,8'hFF,8'h00,8'h00,8'h00,8'h00});
    check("R4 latch kept", latch, 2'd2);
    cpu_write(16'h5001, 8'h55);
    check("R2 setting 1 rejects bit4=0", oreg[1], 8'h00);
    cpu_write(16'h5011, 8'h66);
    check("R2 setting 1 accepts bit4=1", oreg[1], 8'h66);
    for (int k = 0; k < 4; k++) reset_pulse();
    cpu_write(16'h50F1, 8'h77);
    check("R2 setting 5 rejects bit8=0", oreg[1], 8'h00);
    cpu_write(16'h5101, 8'h77);
    check("R2 setting 5 accepts bit8=1", oreg[1], 8'h77);
    for (int k = 0; k < 3; k++) reset_pulse();
    cpu_write(16'h5001, 8'h81);
    check("R2 setting 8 rejects bit11=0", oreg[1], 8'h00);
    reset_pulse();
    cpu_write(16'h5001, 8'h88);
    check("R4 setting 9 accepts via bit12", oreg[1], 8'h88);
    reset_pulse();
    cpu_write(16'h2001, 8'h00);
    cpu_write(16'h5401, 8'h99);
    check("R4 wrap to 0 accepts all", oreg[1], 8'h99);
  endtask

  task automatic t_rst_prio();
    @(negedge clk);
    rst = 1'b1; we = 1'b1; addr = 16'h8000; data = 8'h12;
    #1;
    check("R10 no strobe during reset", {bank_we, irq_we}, 2'b00);
    @(negedge clk);
    rst = 1'b0; we = 1'b0;
    check("R5 reset beats write", oreg[1], 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_power();
    t_low_basic();
    t_force();
    t_ignore();
    t_ext();
    t_pass();
    t_swap();
    t_flat();
    t_reset_dip();
    t_rst_prio();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule